// File: doc/BRIEF.md
# Checkpoint Beep Code Sequencer

This block turns an 8-bit diagnostic checkpoint into an audible pattern on a speaker enable line, for use before any display is available. A one-cycle start strobe captures the code. The block then plays the code as four bursts of beeps. Each burst stands for one 2-bit slice of the code. The burst for a slice holds the slice value plus one beeps, so every burst has one to four beeps. The slice in bits 7:6 is played first and the slice in bits 1:0 is played last.

Beeps inside a burst are separated by a short silence. Consecutive bursts are separated by a longer silence. The beep length, the short silence and the long silence are parameters counted in clock cycles. The output is a plain on/off enable; tone generation is left to the driver circuit. While a pattern plays, `busy` is high. A one-cycle `done` pulse marks the end of the pattern.

Top module: `beep_code_seq`

## Requirements
- R1: The code is played as four bursts, the slice in bits 7:6 first, then bits 5:4, bits 3:2 and bits 1:0. The burst for slice value v holds exactly v+1 beeps; for example 0x4B plays 2, 1, 3, 4 beeps.
- R2: Every beep holds `spk_en` high for exactly BEEP_ON_CYC consecutive cycles.
- R3: Between two beeps of the same burst, `spk_en` is low for exactly BEEP_GAP_CYC cycles.
- R4: Between the last beep of one burst and the first beep of the next, `spk_en` is low for exactly GROUP_GAP_CYC cycles. GROUP_GAP_CYC is strictly greater than BEEP_GAP_CYC, so every pattern has exactly three long silences.
- R5: A start strobe seen while idle makes `spk_en` high in the very next cycle. `busy` stays high from that cycle until the pattern ends.
- R6: A start strobe that arrives while `busy` is high has no effect. The pattern in progress completes unchanged and no new pattern follows.
- R7: In the cycle right after the last beep's final high cycle, `done` is high for exactly one cycle, with `spk_en` low and `busy` low.
- R8: While `rst_n` is sampled low at a clock edge, the block returns to idle. `spk_en`, `busy` and `done` are all low after that edge.
- R9: Code 0x20 plays 1-3-1-1 and code 0x16 plays 1-2-2-3.
- R10: `spk_en` comes straight from a flip-flop, so it never glitches when a beep starts or ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that captures `code` while idle |
| code | input | 8 | Checkpoint value to play |
| spk_en | output | 1 | Registered speaker enable, high during a beep |
| busy | output | 1 | High while a pattern is playing |
| done | output | 1 | One-cycle pulse after the last beep |

## Verification
The first beep is due one cycle after the edge that samples `start`. `done` is due in the cycle right after the last high cycle. Every high run must last BEEP_ON_CYC cycles and every low run must last either BEEP_GAP_CYC or GROUP_GAP_CYC cycles. The bench drives inputs on the falling edge and samples `spk_en`, `busy` and `done` on each later falling edge. It rebuilds the pattern as a list of high and low run lengths and compares each length with these cycle counts. Reset is checked one edge after `rst_n` falls. A start strobe sent mid-pattern is checked by watching the outputs stay low for several cycles after `done`.

// File: rtl/beep_pkg.sv
`timescale 1ns/1ps
// Package: beep_pkg
// Holds the state encoding shared by the beep code sequencer.
// Assumes nothing beyond a two-bit state register.
package beep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a start strobe
        ST_BEEP = 2'd1,   // speaker enabled for one beep
        ST_BGAP = 2'd2,   // short silence inside a burst
        ST_GGAP = 2'd3    // long silence between bursts
    } seq_state_t;
endpackage

// File: rtl/beep_timer.sv
`timescale 1ns/1ps
// Module: beep_timer
// Loadable down-counter that times every phase of the pattern.
// Loading value N makes `expired` go high N cycles later, and it stays
// high until the next load. The counter holds at zero.
// Assumes the caller loads it on the edge that enters a phase.
module beep_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Count down toward zero, or restart from the loaded value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // Phase is over once the count reaches zero.
    always_comb expired = (cnt == '0);

    // R2, R3, R4: phase lengths depend on decrementing by exactly one per cycle.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

    // R2: a load takes effect on the next edge.
    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/beep_group_sel.sv
`timescale 1ns/1ps
// Module: beep_group_sel
// Holds the captured code in a shift register and presents the current
// slice, starting with the most significant one. A step moves to the next
// slice. `last_grp` flags the final slice.
// Assumes `load` and `step` never arrive in the same cycle.
module beep_group_sel #(
    parameter int CODE_W = 8,
    parameter int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              step,
    output logic [GRP_W-1:0]  cur_val,
    output logic              last_grp
);
    localparam int NG = CODE_W / GRP_W;
    localparam int IW = $clog2(NG + 1);

    logic [CODE_W-1:0] shreg;
    logic [IW-1:0]     grp_idx;

    // Capture the code on load and shift one slice per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            grp_idx <= '0;
        end else if (load) begin
            shreg   <= code;
            grp_idx <= '0;
        end else if (step) begin
            shreg   <= {shreg[CODE_W-GRP_W-1:0], {GRP_W{1'b0}}};
            grp_idx <= grp_idx + IW'(1);
        end
    end

    // The top slice of the register is the one being played.
    always_comb cur_val  = shreg[CODE_W-1 -: GRP_W];
    always_comb last_grp = (grp_idx == IW'(NG - 1));

    // R1: each step exposes the next lower slice of the captured code.
    assert_slice_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_val == $past(shreg[CODE_W-GRP_W-1 -: GRP_W])));

    // R1: the slice index advances by one per step.
    assert_index_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (grp_idx == $past(grp_idx) + IW'(1)));
endmodule

// File: rtl/beep_code_seq.sv
`timescale 1ns/1ps
// Module: beep_code_seq
// Plays a checkpoint code as bursts of beeps on a registered speaker
// enable. Each GRP_W-bit slice, most significant first, becomes a burst of
// slice+1 beeps. Beeps are spaced by BEEP_GAP_CYC and bursts by GROUP_GAP_CYC.
// Assumes all durations are at least 1 and GROUP_GAP_CYC > BEEP_GAP_CYC.
module beep_code_seq #(
    parameter int CODE_W        = 8,
    parameter int GRP_W         = 2,
    parameter int BEEP_ON_CYC   = 20_000_000,
    parameter int BEEP_GAP_CYC  = 10_000_000,
    parameter int GROUP_GAP_CYC = 40_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              spk_en,
    output logic              busy,
    output logic              done
);
    import beep_pkg::*;

    localparam int MAX_A = (BEEP_ON_CYC > BEEP_GAP_CYC) ? BEEP_ON_CYC : BEEP_GAP_CYC;
    localparam int MAX_D = (MAX_A > GROUP_GAP_CYC) ? MAX_A : GROUP_GAP_CYC;
    localparam int CW    = $clog2(MAX_D + 1);
    localparam logic [CW-1:0] ON_LD = CW'(BEEP_ON_CYC - 1);
    localparam logic [CW-1:0] BG_LD = CW'(BEEP_GAP_CYC - 1);
    localparam logic [CW-1:0] GG_LD = CW'(GROUP_GAP_CYC - 1);

    seq_state_t       state;
    logic [GRP_W-1:0] rem;       // beeps still to play after the current one
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_done;
    logic             sel_load;
    logic             sel_step;
    logic [GRP_W-1:0] sel_cur;
    logic             sel_last;

    beep_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    beep_group_sel #(.CODE_W(CODE_W), .GRP_W(GRP_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel_load),
        .code     (code),
        .step     (sel_step),
        .cur_val  (sel_cur),
        .last_grp (sel_last)
    );

    // Choose timer reloads and slice moves for the current phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sel_load = 1'b0;
        sel_step = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                tmr_load = 1'b1;
                tmr_val  = ON_LD;
                sel_load = 1'b1;
            end
            ST_BEEP: if (tmr_done) begin
                if (rem != '0) begin
                    tmr_load = 1'b1;
                    tmr_val  = BG_LD;
                end else if (!sel_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = GG_LD;
                    sel_step = 1'b1;
                end
            end
            ST_BGAP, ST_GGAP: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = ON_LD;
            end
            default: ;
        endcase
    end

    // Sequence the phases and register the speaker enable and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rem    <= '0;
            spk_en <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_BEEP;
                    rem    <= code[CODE_W-1 -: GRP_W];
                    spk_en <= 1'b1;
                end
                ST_BEEP: if (tmr_done) begin
                    spk_en <= 1'b0;
                    if (rem != '0) begin
                        state <= ST_BGAP;
                        rem   <= rem - GRP_W'(1);
                    end else if (!sel_last) begin
                        state <= ST_GGAP;
                    end else begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_BGAP: if (tmr_done) begin
                    state  <= ST_BEEP;
                    spk_en <= 1'b1;
                end
                ST_GGAP: if (tmr_done) begin
                    state  <= ST_BEEP;
                    rem    <= sel_cur;
                    spk_en <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy whenever a pattern is under way.
    always_comb busy = (state != ST_IDLE);

    // R7: done lasts exactly one cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: at done the speaker is silent and the block is free.
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!spk_en && !busy));

    // R10: the speaker is never enabled outside a pattern.
    assert_spk_in_pattern_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spk_en |-> busy);

    // R5: a start seen while idle turns the speaker on at the next edge.
    assert_start_beep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (spk_en && busy));

    // R6: a start while busy never reloads the slice register.
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sel_load);

    // R4: a long silence is entered only after a burst's final beep.
    assert_group_gap_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEEP && tmr_done && rem != '0) |=> (state == ST_BGAP));

    // R8: reset clears every output at the next edge.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!spk_en && !busy && !done));
endmodule

// File: tb/tb_beep_code_seq.sv
`timescale 1ns/1ps
module tb_beep_code_seq;
    localparam int ON = 3;
    localparam int BG = 2;
    localparam int GG = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] code = 8'h00;
    logic       spk_en, busy, done;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    beep_code_seq #(.CODE_W(8), .GRP_W(2), .BEEP_ON_CYC(ON),
                    .BEEP_GAP_CYC(BG), .GROUP_GAP_CYC(GG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .spk_en(spk_en), .busy(busy), .done(done));

    always #5 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Strobe start for one cycle; the design samples it at the next edge.
    task automatic pulse_start(input logic [7:0] c);
        @(negedge clk);
        code  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Play one code, rebuild its runs and check them against the rules.
    // If mid > 0, a start strobe with another code is sent at that sample.
    task automatic play_and_check(input logic [7:0] c, input int mid);
        int lvl[0:63];
        int len[0:63];
        int nr = 0;
        int prev = 1;
        int cur = 0;
        int n = 0;
        bit got_done = 1'b0;
        int burst = 0;
        int grp = 0;
        int bad_hi = 0;
        int bad_lo = 0;
        int n_gg = 0;
        int exp_b;
        code  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(spk_en == 1'b1, "R5", "first beep one cycle after start", int'(spk_en), 1);
        chk(busy == 1'b1, "R5", "busy with first beep", int'(busy), 1);
        cur = 1;
        for (int i = 0; i < 400; i++) begin
            if (mid > 0 && n == mid) begin
                code  = ~c;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            n = n + 1;
            if (done) begin
                got_done = 1'b1;
                break;
            end
            if (!busy) begin
                chk(1'b0, "R5", "busy during pattern", 0, 1);
            end
            if (int'(spk_en) == prev) cur = cur + 1;
            else begin
                if (nr < 64) begin lvl[nr] = prev; len[nr] = cur; nr = nr + 1; end
                prev = int'(spk_en);
                cur  = 1;
            end
        end
        chk(got_done, "R7", "done seen", int'(got_done), 1);
        if (!got_done) return;
        chk(prev == 1, "R7", "done right after last high cycle", prev, 1);
        chk(!spk_en && !busy, "R7", "quiet at done", int'(spk_en) + int'(busy), 0);
        if (nr < 64) begin lvl[nr] = prev; len[nr] = cur; nr = nr + 1; end
        // Split the runs into bursts and compare with the slice values.
        for (int k = 0; k < nr; k++) begin
            if (lvl[k] == 1) begin
                if (len[k] != ON) bad_hi = bad_hi + 1;
                burst = burst + 1;
            end else if (len[k] == GG) begin
                n_gg  = n_gg + 1;
                exp_b = int'((c >> (6 - 2 * grp)) & 8'h3) + 1;
                chk(burst == exp_b, "R1", "beeps in burst", burst, exp_b);
                grp   = grp + 1;
                burst = 0;
            end else if (len[k] != BG) begin
                bad_lo = bad_lo + 1;
            end
        end
        exp_b = int'(c & 8'h3) + 1;
        chk(burst == exp_b, "R1", "beeps in last burst", burst, exp_b);
        chk(bad_hi == 0, "R2", "beeps of wrong length", bad_hi, 0);
        chk(bad_lo == 0, "R3", "short gaps of wrong length", bad_lo, 0);
        chk(n_gg == 3, "R4", "long gaps", n_gg, 3);
        @(negedge clk);
        chk(!done, "R7", "done one cycle only", int'(done), 0);
    endtask

    // Reset state right after power-up.
    task automatic test_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!spk_en && !busy && !done, "R8", "outputs in reset",
            int'(spk_en) + int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Several codes, including the all-zero and all-one slices.
    task automatic test_patterns();
        play_and_check(8'h4B, 0);
        play_and_check(8'h00, 0);
        play_and_check(8'hFF, 0);
        play_and_check(8'hE4, 0);
    endtask

    // The two fixed examples.
    task automatic test_examples_R9();
        play_and_check(8'h20, 0);
        play_and_check(8'h16, 0);
    endtask

    // Start during a pattern is ignored and causes no replay.
    task automatic test_start_ignored_R6();
        int stray = 0;
        play_and_check(8'h2C, 5);
        for (int i = 0; i < 2 * GG; i++) begin
            @(negedge clk);
            if (spk_en || busy) stray = stray + 1;
        end
        chk(stray == 0, "R6", "activity after done", stray, 0);
    endtask

    // Reset in the middle of a pattern silences it at once.
    task automatic test_mid_reset_R8();
        int stray = 0;
        pulse_start(8'hFF);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!spk_en && !busy && !done, "R8", "outputs after mid reset",
            int'(spk_en) + int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (spk_en || busy) stray = stray + 1;
        end
        chk(stray == 0, "R8", "stays idle after reset", stray, 0);
        play_and_check(8'h4B, 0);
    endtask

    initial begin
        test_reset_state();
        test_patterns();
        test_examples_R9();
        test_start_ignored_R6();
        test_mid_reset_R8();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule